// File: doc/BRIEF.md
# Section Trace Checker with AIS Request

This block watches the section-trace byte that arrives once per frame. It locks onto the start-marker byte and collects a 16-byte trace message. It computes the CRC7 of each collected message and compares the message with a programmable expected string. It then raises two alarms: one for a CRC failure and one for a trace mismatch. A CRC failure hides the mismatch alarm, because a corrupted message says nothing about whether the connection is correct. One configuration input switches all trace checking off.

The block also produces a downstream AIS request. The request is driven by the loss-of-signal input, the loss-of-frame input and the trace-mismatch alarm, and each of these has its own enable. A test input forces the request on regardless of the three conditions. Frame alignment, register decoding and the all-ones substitution itself are done elsewhere. This block only decides and reports.

Top module: `sec_trace_mon`

## Requirements
- R1: A message begins at a sampled byte (frame_stb high) whose bit 7 is 1. That byte is byte 0. The next 15 sampled bytes become bytes 1 to 15, and the message is judged once byte 15 arrives.
- R1 (continued): Sampled bytes with bit 7 at 0 are ignored while no message is open. A message is no longer open after it is judged, or before the first marker arrives.
- R1 (continued): A marker byte that arrives inside an open message abandons that message and starts a new one.
- R2: The CRC7 uses the generator x^7+x^3+1. It is computed over bytes 0 to 15, each byte fed MSB first, with the low 7 bits of byte 0 taken as zero. crc_err becomes 1 when this value differs from bits 6:0 of byte 0, and 0 when they match. It is updated for every judged message.
- R3: trace_mm becomes 1 when the judged message passes its CRC check but differs in any bit from exp_trace. exp_trace holds byte i at bits 8i+7:8i, and byte 0 is the marker byte including its CRC field. trace_mm becomes 0 when the message equals exp_trace.
- R4: A judged message that fails its CRC check sets trace_mm to 0, whatever its content. crc_err and trace_mm are therefore never 1 together.
- R5: While trace_off is 1, crc_err and trace_mm read 0 from the clock edge after trace_off is first sampled high. Messages completed while trace_off is 1 leave both alarms at 0. After trace_off returns to 0, the alarms stay 0 until the next judged message.
- R6: With ais_en_los at 1, los at 1 makes ais_active 1 one clock later. With ais_en_los at 0, los has no effect on ais_active.
- R7: With ais_en_lof at 1, lof at 1 makes ais_active 1 one clock later. With ais_en_lof at 0, lof has no effect on ais_active.
- R8: With ais_en_mm at 1, trace_mm at 1 makes ais_active 1 one clock later. With ais_en_mm at 0, the mismatch alarm has no effect on ais_active.
- R9: ais_force at 1 makes ais_active 1 one clock later, regardless of all other inputs. With ais_force at 0 and no enabled condition active, ais_active is 0.
- R10: After reset, crc_err, trace_mm and ais_active are 0. The alarms take a judged message's result at the second rising edge, counting the edge that samples byte 15 as the first. ais_active reflects that result one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | High for one cycle per frame when trace_byte is valid |
| trace_byte | input | 8 | Received section-trace byte |
| los | input | 1 | Loss-of-signal indication |
| lof | input | 1 | Loss-of-frame indication |
| trace_off | input | 1 | Disables all trace checking and clears the trace alarms |
| ais_en_los | input | 1 | Lets LOS request AIS |
| ais_en_lof | input | 1 | Lets LOF request AIS |
| ais_en_mm | input | 1 | Lets the trace mismatch alarm request AIS |
| ais_force | input | 1 | Test input that forces the AIS request |
| exp_trace | input | 128 | Expected 16-byte message, byte i at bits 8i+7:8i |
| crc_err | output | 1 | CRC7 failure on the last judged message |
| trace_mm | output | 1 | Trace mismatch on the last judged message (masked by crc_err) |
| ais_active | output | 1 | Downstream AIS insertion request |

## Verification
The assertions check these rules on every cycle:
- The two alarms are never raised together.
- The alarms are cleared whenever trace checking is off.
- The alarms hold their value between judged messages.
- Each enabled AIS cause, and the force input, drives ais_active one cycle later.

Only the bench scenarios can show that the CRC7 value, the byte alignment and the restart on an early marker are right. They also show the exact edge at which a judged result appears, and that a disabled cause leaves ais_active low. To show these, the bench sends messages that are correct, differently valid, data-corrupted and CRC-corrupted. It also sends stray bytes and truncated messages.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int MSG_BYTES = 16;
    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^3 + 1 terms of x^7+x^3+1
    localparam int N_CAUSE   = 3;

    typedef enum logic [1:0] {
        CAUSE_MM  = 2'd0,
        CAUSE_LOS = 2'd1,
        CAUSE_LOF = 2'd2
    } cause_e;

    typedef struct packed {
        logic             done;
        logic [CRC_W-1:0] calc;
        logic [CRC_W-1:0] rxcrc;
    } trc_evt_t;

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                   input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/trc_align.sv
module trc_align
    import trc_pkg::*;
#(
    parameter int MSG_LEN = MSG_BYTES,
    localparam int IDX_W  = $clog2(MSG_LEN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          stb,
    input  logic [BYTE_W-1:0]             byte_i,
    output trc_evt_t                      evt,
    output logic [MSG_LEN-1:0][BYTE_W-1:0] msg
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(MSG_LEN - 1);

    logic                           open_q;
    logic [IDX_W-1:0]               idx_q;
    logic [CRC_W-1:0]               crc_q;
    logic [MSG_LEN-1:0][BYTE_W-1:0] store_q;
    logic [MSG_LEN-1:0][BYTE_W-1:0] store_n;
    logic [CRC_W-1:0]               crc_n;
    logic                           is_marker;
    trc_evt_t                       evt_q;

    assign is_marker = byte_i[BYTE_W-1];

    // The marker's CRC field is replaced by zeros for the calculation
    always_comb begin
        store_n = store_q;
        crc_n   = crc_q;
        if (is_marker) begin
            store_n[0] = byte_i;
            crc_n      = crc7_step('0, {1'b1, {(BYTE_W-1){1'b0}}});
        end else if (open_q) begin
            store_n[idx_q] = byte_i;
            crc_n          = crc7_step(crc_q, byte_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            idx_q    <= '0;
            crc_q    <= '0;
            store_q  <= '0;
            evt_q    <= '0;
            msg      <= '0;
        end else begin
            evt_q.done <= 1'b0;
            if (stb) begin
                store_q <= store_n;
                crc_q   <= crc_n;
                if (is_marker) begin
                    open_q <= 1'b1;
                    idx_q  <= IDX_W'(1);
                end else if (open_q) begin
                    if (idx_q == LAST) begin
                        open_q      <= 1'b0;
                        idx_q       <= '0;
                        evt_q.done  <= 1'b1;
                        evt_q.calc  <= crc_n;
                        evt_q.rxcrc <= store_q[0][CRC_W-1:0];
                        msg         <= store_n;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
            end
        end
    end

    assign evt = evt_q;

endmodule

// File: rtl/trc_judge.sv
module trc_judge
    import trc_pkg::*;
#(
    parameter int MSG_LEN = MSG_BYTES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           off,
    input  trc_evt_t                       evt,
    input  logic [MSG_LEN-1:0][BYTE_W-1:0] msg,
    input  logic [MSG_LEN-1:0][BYTE_W-1:0] expect_msg,
    output logic                           crc_err,
    output logic                           mism
);

    logic crc_bad;
    logic differs;

    assign crc_bad = (evt.calc != evt.rxcrc);
    assign differs = (msg != expect_msg);

    always_ff @(posedge clk) begin
        if (rst || off) begin
            crc_err <= 1'b0;
            mism    <= 1'b0;
        end else if (evt.done) begin
            crc_err <= crc_bad;
            mism    <= differs && !crc_bad;
        end
    end

endmodule

// File: rtl/trc_ais.sv
module trc_ais
    import trc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CAUSE-1:0] cause,
    input  logic [N_CAUSE-1:0] enable,
    input  logic               force_i,
    output logic               ais
);

    logic [N_CAUSE-1:0] gated;

    for (genvar g = 0; g < N_CAUSE; g++) begin : g_cause
        assign gated[g] = cause[g] & enable[g];
    end

    always_ff @(posedge clk) begin
        if (rst) ais <= 1'b0;
        else     ais <= force_i | (|gated);
    end

endmodule

// File: rtl/sec_trace_mon.sv
module sec_trace_mon
    import trc_pkg::*;
#(
    parameter int MSG_LEN = MSG_BYTES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_stb,
    input  logic [BYTE_W-1:0]         trace_byte,
    input  logic                      los,
    input  logic                      lof,
    input  logic                      trace_off,
    input  logic                      ais_en_los,
    input  logic                      ais_en_lof,
    input  logic                      ais_en_mm,
    input  logic                      ais_force,
    input  logic [MSG_LEN*BYTE_W-1:0] exp_trace,
    output logic                      crc_err,
    output logic                      trace_mm,
    output logic                      ais_active
);

    trc_evt_t                       evt;
    logic [MSG_LEN-1:0][BYTE_W-1:0] msg;
    logic [MSG_LEN-1:0][BYTE_W-1:0] expect_msg;
    logic [N_CAUSE-1:0]             cause;
    logic [N_CAUSE-1:0]             enable;

    assign expect_msg = exp_trace;

    assign cause[CAUSE_MM]   = trace_mm;
    assign cause[CAUSE_LOS]  = los;
    assign cause[CAUSE_LOF]  = lof;
    assign enable[CAUSE_MM]  = ais_en_mm;
    assign enable[CAUSE_LOS] = ais_en_los;
    assign enable[CAUSE_LOF] = ais_en_lof;

    trc_align #(.MSG_LEN(MSG_LEN)) u_align (
        .clk    (clk),
        .rst    (rst),
        .stb    (frame_stb),
        .byte_i (trace_byte),
        .evt    (evt),
        .msg    (msg)
    );

    trc_judge #(.MSG_LEN(MSG_LEN)) u_judge (
        .clk        (clk),
        .rst        (rst),
        .off        (trace_off),
        .evt        (evt),
        .msg        (msg),
        .expect_msg (expect_msg),
        .crc_err    (crc_err),
        .mism       (trace_mm)
    );

    trc_ais u_ais (
        .clk     (clk),
        .rst     (rst),
        .cause   (cause),
        .enable  (enable),
        .force_i (ais_force),
        .ais     (ais_active)
    );

endmodule

// File: rtl/sec_trace_mon_chk.sv
module sec_trace_mon_chk (
    input logic clk,
    input logic rst,
    input logic evt_done,
    input logic trace_off,
    input logic los,
    input logic lof,
    input logic ais_en_los,
    input logic ais_en_lof,
    input logic ais_en_mm,
    input logic ais_force,
    input logic crc_err,
    input logic trace_mm,
    input logic ais_active
);

    // R4
    mask_excl_chk: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> !trace_mm);

    // R5
    off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        trace_off |=> (!crc_err && !trace_mm));

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt_done && !trace_off) |=> $stable({crc_err, trace_mm}));

    // R6
    los_ais_chk: assert property (@(posedge clk) disable iff (rst)
        (los && ais_en_los) |=> ais_active);

    // R7
    lof_ais_chk: assert property (@(posedge clk) disable iff (rst)
        (lof && ais_en_lof) |=> ais_active);

    // R8
    mm_ais_chk: assert property (@(posedge clk) disable iff (rst)
        (trace_mm && ais_en_mm) |=> ais_active);

    // R9
    force_ais_chk: assert property (@(posedge clk) disable iff (rst)
        ais_force |=> ais_active);

endmodule

bind sec_trace_mon sec_trace_mon_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_done   (evt.done),
    .trace_off  (trace_off),
    .los        (los),
    .lof        (lof),
    .ais_en_los (ais_en_los),
    .ais_en_lof (ais_en_lof),
    .ais_en_mm  (ais_en_mm),
    .ais_force  (ais_force),
    .crc_err    (crc_err),
    .trace_mm   (trace_mm),
    .ais_active (ais_active)
);

// File: tb/sec_trace_mon_tb.sv
module sec_trace_mon_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         frame_stb;
    logic [7:0]   trace_byte;
    logic         los, lof, trace_off;
    logic         ais_en_los, ais_en_lof, ais_en_mm, ais_force;
    logic [127:0] exp_trace;
    logic         crc_err, trace_mm, ais_active;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sec_trace_mon u_dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .trace_byte(trace_byte),
        .los(los), .lof(lof), .trace_off(trace_off),
        .ais_en_los(ais_en_los), .ais_en_lof(ais_en_lof), .ais_en_mm(ais_en_mm),
        .ais_force(ais_force), .exp_trace(exp_trace),
        .crc_err(crc_err), .trace_mm(trace_mm), .ais_active(ais_active)
    );

    // Reference CRC: long division of the 128-bit message times x^7
    function automatic logic [6:0] ref_crc(input logic [127:0] m);
        logic [134:0] v;
        v = '0;
        for (int i = 0; i < 16; i++)
            v[134 - 8*i -: 8] = (i == 0) ? 8'h80 : m[8*i +: 8];
        for (int k = 134; k >= 7; k--)
            if (v[k]) v[k -: 8] = v[k -: 8] ^ 8'h89;
        return v[6:0];
    endfunction

    function automatic logic [127:0] make_msg(input logic [7:0] base);
        logic [127:0] m;
        m = '0;
        for (int i = 1; i < 16; i++) m[8*i +: 8] = (base + 8'(i)) & 8'h7f;
        m[7:0] = {1'b1, ref_crc(m)};
        return m;
    endfunction

    logic [127:0] good_m, other_m, derr_m, cerr_m;

    task automatic check(input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        frame_stb  = 1'b1;
        trace_byte = b;
        @(negedge clk);
        frame_stb  = 1'b0;
    endtask

    task automatic send_msg(input logic [127:0] m);
        for (int i = 0; i < 16; i++) send_byte(m[8*i +: 8]);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // {sel[1:0], los, lof, en_los, en_lof, en_mm, force, e_crc, e_mm, e_ais}
    // sel: 0 good, 1 other valid, 2 data error, 3 CRC field error
    localparam int NV = 11;
    localparam logic [10:0] VEC [NV] = '{
        11'b00_00_000_0_000,
        11'b01_00_001_0_011,
        11'b01_00_000_0_010,
        11'b10_00_001_0_100,
        11'b11_00_001_0_100,
        11'b00_10_100_0_001,
        11'b00_10_000_0_000,
        11'b00_01_010_0_001,
        11'b00_11_000_0_000,
        11'b00_00_000_1_001,
        11'b01_00_000_1_011
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] m;
        good_m  = make_msg(8'h30);
        other_m = make_msg(8'h50);
        derr_m  = good_m ^ (128'h01 << 40);
        cerr_m  = good_m ^ 128'h01;

        rst = 1'b1; frame_stb = 1'b0; trace_byte = '0; los = 0; lof = 0;
        trace_off = 0; ais_en_los = 0; ais_en_lof = 0; ais_en_mm = 0; ais_force = 0;
        exp_trace = good_m;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset crc_err", crc_err, 1'b0);
        check("R10 reset trace_mm", trace_mm, 1'b0);
        check("R10 reset ais_active", ais_active, 1'b0);

        // Table walk: R2 R3 R4 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            case (VEC[v][10:9])
                2'd0: m = good_m;
                2'd1: m = other_m;
                2'd2: m = derr_m;
                default: m = cerr_m;
            endcase
            los = VEC[v][8]; lof = VEC[v][7];
            ais_en_los = VEC[v][6]; ais_en_lof = VEC[v][5];
            ais_en_mm = VEC[v][4]; ais_force = VEC[v][3];
            send_msg(m);
            settle();
            check($sformatf("R2 vec%0d crc_err", v), crc_err, VEC[v][2]);
            check($sformatf("R3/R4 vec%0d trace_mm", v), trace_mm, VEC[v][1]);
            check($sformatf("R6-9 vec%0d ais_active", v), ais_active, VEC[v][0]);
        end
        los = 0; lof = 0; ais_en_los = 0; ais_en_lof = 0; ais_force = 0; ais_en_mm = 1;

        // R10 latency: good first, then other message
        send_msg(good_m);
        settle();
        for (int i = 0; i < 16; i++) send_byte(other_m[8*i +: 8]);
        check("R10 mm not yet after first edge", trace_mm, 1'b0);
        @(negedge clk);
        check("R10 mm after second edge", trace_mm, 1'b1);
        check("R10 ais not yet after second edge", ais_active, 1'b0);
        @(negedge clk);
        check("R10 ais after third edge", ais_active, 1'b1);

        // R1 stray non-marker bytes are ignored while no message is open
        for (int i = 0; i < 20; i++) send_byte(8'h11 + 8'(i));
        settle();
        check("R1 stray bytes keep trace_mm", trace_mm, 1'b1);

        // R1 early marker restarts: partial other message then full good one
        for (int i = 0; i < 6; i++) send_byte(other_m[8*i +: 8]);
        send_msg(good_m);
        settle();
        check("R1 restart on marker trace_mm", trace_mm, 1'b0);
        check("R1 restart on marker crc_err", crc_err, 1'b0);

        // R5 trace checking off
        send_msg(other_m);
        settle();
        check("R5 precondition trace_mm", trace_mm, 1'b1);
        trace_off = 1'b1;
        @(negedge clk);
        check("R5 off clears trace_mm", trace_mm, 1'b0);
        send_msg(cerr_m);
        settle();
        check("R5 off keeps crc_err low", crc_err, 1'b0);
        check("R5 off keeps ais low", ais_active, 1'b0);
        trace_off = 1'b0;
        settle();
        check("R5 alarms stay low after re-enable", trace_mm, 1'b0);
        send_msg(other_m);
        settle();
        check("R5 next message judged after re-enable", trace_mm, 1'b1);

        // R9 no cause, no force
        ais_en_mm = 1'b0;
        settle();
        check("R9 idle ais_active", ais_active, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule